// File: doc/BRIEF.md
# Machine-Mode Trap and Cycle CSR Unit

This unit holds four machine-level control registers of a 32-bit core: the trap vector base, the exception program counter, and a 64-bit cycle counter kept as a low and a high 32-bit half. An instruction pipeline sends it one CSR access per cycle. Each access carries a 12-bit address, a 3-bit operation code, a 5-bit immediate taken from the register-specifier field, a register source value and a write enable. The unit returns the register's previous content for the destination register in the same cycle. The written value takes effect at the next clock edge.

The unit also steers control flow. A trap request carries the PC of the faulting instruction. The unit records that PC in the exception PC register and, in the same cycle, presents a redirect to the trap vector base with its two low bits cleared. Only direct mode is supported. A return request presents a redirect to the value currently held in the exception PC register. Software can rewrite that register beforehand, for example to step past the trapping instruction by 2 bytes for a compressed instruction or by 4 bytes otherwise.

The low half of the counter advances on every clock and carries into the high half when it wraps. A software write to either half wins over counting in that clock.

Top module: `mcsr_unit`

## Requirements
- R1: The four supported addresses are 0x305 (trap vector), 0x341 (exception PC), 0xB00 (cycle counter low half) and 0xB80 (cycle counter high half). For a legal access, `acc_rdata` is combinationally the addressed register's content before the access.
- R2: Operation code bits [1:0] select the kind: 01 write, 10 set, 11 clear. Bit 2 set selects the immediate source, which is `acc_imm` zero-extended to 32 bits; bit 2 clear selects `acc_rs1`. A write stores the source value.
- R3: A set stores the old value OR the source. A clear stores the old value AND the inverted source.
- R4: A set or clear whose source is zero writes nothing. An access with `acc_wen` low writes nothing.
- R5: An access with `acc_valid` high to an unsupported address, or with operation code 000 or 100, raises `acc_illegal` in that cycle, returns zero on `acc_rdata` and changes no register.
- R6: Both counter halves are zero while `rst_n` is low. The low half increments by one on every clock after reset.
- R7: When the low half steps from 0xFFFFFFFF to zero, the high half increments by one on the same edge.
- R8: A write to a counter half replaces that half's increment or carry in that clock. Counting continues from the written value on the next clock.
- R9: On `trap_req`, `redirect_valid` is high and `redirect_pc` is the trap vector with bits [1:0] forced to zero, in the same cycle. The exception PC register loads `trap_pc` at the next edge.
- R10: On `ret_req` without `trap_req`, `redirect_valid` is high and `redirect_pc` equals the exception PC register, including any value software has written to it.
- R11: When `trap_req` is high, a CSR write in the same cycle is discarded, and the trap wins over a simultaneous return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | CSR access present this cycle |
| acc_addr | input | 12 | CSR address |
| acc_op | input | 3 | Operation code (bit 2 = immediate, [1:0] = write/set/clear) |
| acc_imm | input | 5 | Immediate source from the register-specifier field |
| acc_rs1 | input | 32 | Register source value |
| acc_wen | input | 1 | Write permitted for this access |
| acc_rdata | output | 32 | Previous CSR content for the destination register |
| acc_illegal | output | 1 | Access to an unsupported address or with a reserved operation |
| trap_req | input | 1 | Trap taken this cycle |
| trap_pc | input | 32 | PC of the trapping instruction |
| ret_req | input | 1 | Return from trap this cycle |
| redirect_valid | output | 1 | Fetch redirect present |
| redirect_pc | output | 32 | Redirect target |

## Verification
The bench targets the low-half wrap at 0xFFFFFFFF. A design that drops the carry leaves the high half still, and one that carries on a software write to the low half bumps the high half by mistake. It writes an unaligned trap vector and then raises a trap. An unmasked redirect would then show the low bits, and a wrong capture would show up when the exception PC is read back or when a return follows a software rewrite of +2 or +4. It checks set and clear with a zero immediate, reserved operation codes, unknown addresses, and a CSR write that coincides with a trap. In each case a faulty design alters a register, which shows up in a later read.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

   typedef enum logic [2:0] {
      OP_NONE = 3'b000,
      OP_RW   = 3'b001,
      OP_RS   = 3'b010,
      OP_RC   = 3'b011,
      OP_RSV  = 3'b100,
      OP_RWI  = 3'b101,
      OP_RSI  = 3'b110,
      OP_RCI  = 3'b111
   } csr_op_e;

   localparam logic [11:0] ADDR_TVEC   = 12'h305;
   localparam logic [11:0] ADDR_EPC    = 12'h341;
   localparam logic [11:0] ADDR_CYC_LO = 12'hB00;
   localparam logic [11:0] ADDR_CYC_HI = 12'hB80;

   typedef struct packed {
      logic tvec;
      logic epc;
      logic cyc_lo;
      logic cyc_hi;
   } csr_sel_t;

endpackage

// File: rtl/mcsr_rmw.sv
module mcsr_rmw #(
   parameter int XLEN  = 32,
   parameter int IMM_W = 5
) (
   input  logic [2:0]      op,
   input  logic [IMM_W-1:0] imm,
   input  logic [XLEN-1:0] reg_src,
   input  logic [XLEN-1:0] old_val,
   output logic [XLEN-1:0] new_val,
   output logic            op_ok,
   output logic            writes
);
   import mcsr_pkg::*;

   localparam int PAD_W = XLEN - IMM_W;

   logic [XLEN-1:0] src;

   generate
      if (PAD_W > 0) begin : g_pad
         always_comb src = op[2] ? {{PAD_W{1'b0}}, imm} : reg_src;
      end else begin : g_nopad
         always_comb src = op[2] ? imm[XLEN-1:0] : reg_src;
      end
   endgenerate

   always_comb begin
      new_val = old_val;
      op_ok   = 1'b1;
      writes  = 1'b0;
      unique case (op[1:0])
         2'b01: begin
            new_val = src;
            writes  = 1'b1;
         end
         2'b10: begin
            new_val = old_val | src;
            writes  = |src;
         end
         2'b11: begin
            new_val = old_val & ~src;
            writes  = |src;
         end
         default: op_ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/mcsr_cycle.sv
module mcsr_cycle #(
   parameter int HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_we,
   input  logic              hi_we,
   input  logic [HALF_W-1:0] wdata,
   output logic [HALF_W-1:0] lo,
   output logic [HALF_W-1:0] hi
);

   logic wrap;

   assign wrap = &lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo <= '0;
      end else if (lo_we) begin
         lo <= wdata;
      end else begin
         lo <= lo + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi <= '0;
      end else if (hi_we) begin
         hi <= wdata;
      end else if (wrap && !lo_we) begin
         hi <= hi + 1'b1;
      end
   end

   AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_we |=> lo == $past(lo) + 1'b1); // R6
   AST_HI_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (!lo_we && !hi_we && lo == {HALF_W{1'b1}}) |=> hi == $past(hi) + 1'b1); // R7
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we |=> lo == $past(wdata)); // R8

endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit #(
   parameter int XLEN      = 32,
   parameter int ADDR_W    = 12,
   parameter int IMM_W     = 5,
   parameter int ALIGN_LSB = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [2:0]        acc_op,
   input  logic [IMM_W-1:0]  acc_imm,
   input  logic [XLEN-1:0]   acc_rs1,
   input  logic              acc_wen,
   output logic [XLEN-1:0]   acc_rdata,
   output logic              acc_illegal,
   input  logic              trap_req,
   input  logic [XLEN-1:0]   trap_pc,
   input  logic              ret_req,
   output logic              redirect_valid,
   output logic [XLEN-1:0]   redirect_pc
);
   import mcsr_pkg::*;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mcsr_unit supports XLEN = 32 only");
      end
      if (ADDR_W != 12) begin : g_bad_addr
         $error("mcsr_unit needs a 12-bit CSR address");
      end
      if (IMM_W > XLEN || ALIGN_LSB < 1 || ALIGN_LSB >= XLEN) begin : g_bad_field
         $error("mcsr_unit field widths out of range");
      end
   endgenerate

   csr_sel_t        sel;
   logic            hit;
   logic [XLEN-1:0] tvec_q, epc_q, cyc_lo, cyc_hi;
   logic [XLEN-1:0] old_val, new_val, vec_base;
   logic            op_ok, writes, wr_en;

   always_comb begin
      sel.tvec   = acc_addr == ADDR_TVEC;
      sel.epc    = acc_addr == ADDR_EPC;
      sel.cyc_lo = acc_addr == ADDR_CYC_LO;
      sel.cyc_hi = acc_addr == ADDR_CYC_HI;
      hit        = |sel;
   end

   always_comb begin
      old_val = '0;
      unique case (1'b1)
         sel.tvec:   old_val = tvec_q;
         sel.epc:    old_val = epc_q;
         sel.cyc_lo: old_val = cyc_lo;
         sel.cyc_hi: old_val = cyc_hi;
         default:    old_val = '0;
      endcase
   end

   mcsr_rmw #(.XLEN(XLEN), .IMM_W(IMM_W)) i_rmw (
      .op      (acc_op),
      .imm     (acc_imm),
      .reg_src (acc_rs1),
      .old_val (old_val),
      .new_val (new_val),
      .op_ok   (op_ok),
      .writes  (writes)
   );

   assign acc_illegal = acc_valid && !(hit && op_ok);
   assign acc_rdata   = (acc_valid && !acc_illegal) ? old_val : '0;
   assign wr_en       = acc_valid && acc_wen && hit && op_ok && writes && !trap_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tvec_q <= '0;
      end else if (wr_en && sel.tvec) begin
         tvec_q <= new_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         epc_q <= '0;
      end else if (trap_req) begin
         epc_q <= trap_pc;
      end else if (wr_en && sel.epc) begin
         epc_q <= new_val;
      end
   end

   mcsr_cycle #(.HALF_W(XLEN)) i_cycle (
      .clk   (clk),
      .rst_n (rst_n),
      .lo_we (wr_en && sel.cyc_lo),
      .hi_we (wr_en && sel.cyc_hi),
      .wdata (new_val),
      .lo    (cyc_lo),
      .hi    (cyc_hi)
   );

   assign vec_base       = {tvec_q[XLEN-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
   assign redirect_valid = trap_req || ret_req;
   assign redirect_pc    = trap_req ? vec_base : (ret_req ? epc_q : '0);

   AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> epc_q == $past(trap_pc)); // R9
   AST_TRAP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> redirect_valid && redirect_pc[ALIGN_LSB-1:0] == '0); // R9
   AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && acc_addr == ADDR_TVEC) |=> tvec_q == $past(tvec_q)); // R11
   AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_illegal && !trap_req) |=> tvec_q == $past(tvec_q) && epc_q == $past(epc_q)); // R5

endmodule

// File: tb/test_mcsr_unit.sv
`timescale 1ns/1ps
module test_mcsr_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [11:0] acc_addr = '0;
   logic [2:0]  acc_op = '0;
   logic [4:0]  acc_imm = '0;
   logic [31:0] acc_rs1 = '0;
   logic        acc_wen = 1'b0;
   logic [31:0] acc_rdata;
   logic        acc_illegal;
   logic        trap_req = 1'b0;
   logic [31:0] trap_pc = '0;
   logic        ret_req = 1'b0;
   logic        redirect_valid;
   logic [31:0] redirect_pc;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   mcsr_unit i_mcsr_unit (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_op(acc_op), .acc_imm(acc_imm), .acc_rs1(acc_rs1), .acc_wen(acc_wen),
      .acc_rdata(acc_rdata), .acc_illegal(acc_illegal), .trap_req(trap_req),
      .trap_pc(trap_pc), .ret_req(ret_req), .redirect_valid(redirect_valid),
      .redirect_pc(redirect_pc)
   );

   // behavioural reference state
   logic [31:0] m_vec, m_pc, m_lo, m_hi;

   function automatic logic [31:0] m_read(input logic [11:0] a);
      case (a)
         12'h305: return m_vec;
         12'h341: return m_pc;
         12'hB00: return m_lo;
         12'hB80: return m_hi;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit m_legal(input logic [11:0] a, input logic [2:0] op);
      return (a == 12'h305 || a == 12'h341 || a == 12'hB00 || a == 12'hB80) && op[1:0] != 2'b00;
   endfunction

   always @(posedge clk or negedge rst_n) begin : model
      logic [31:0] s, o, n;
      bit w;
      if (!rst_n) begin
         m_vec <= 0; m_pc <= 0; m_lo <= 0; m_hi <= 0;
      end else begin
         s = acc_op[2] ? {27'd0, acc_imm} : acc_rs1;
         o = m_read(acc_addr);
         n = (acc_op[1:0] == 2'b01) ? s : (acc_op[1:0] == 2'b10) ? (o | s) : (o & ~s);
         w = acc_valid && acc_wen && m_legal(acc_addr, acc_op) && !trap_req
             && (acc_op[1:0] == 2'b01 || s != 0);
         if (w && acc_addr == 12'h305) m_vec <= n;
         if (trap_req) m_pc <= trap_pc;
         else if (w && acc_addr == 12'h341) m_pc <= n;
         if (w && acc_addr == 12'hB00) m_lo <= n;
         else m_lo <= m_lo + 1;
         if (w && acc_addr == 12'hB80) m_hi <= n;
         else if (!(w && acc_addr == 12'hB00) && m_lo == 32'hFFFF_FFFF) m_hi <= m_hi + 1;
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // compare every output against the model on every driven cycle
   task automatic compare(input string tag);
      logic [31:0] er;
      bit il;
      il = acc_valid && !m_legal(acc_addr, acc_op);
      er = (acc_valid && !il) ? m_read(acc_addr) : 32'h0;
      chk(tag, "rdata", acc_rdata, er);
      chk(tag, "illegal", {31'd0, acc_illegal}, {31'd0, il});
      chk(tag, "redir_valid", {31'd0, redirect_valid}, {31'd0, trap_req | ret_req});
      if (trap_req) chk(tag, "redir_pc", redirect_pc, {m_vec[31:2], 2'b00});
      else if (ret_req) chk(tag, "redir_pc", redirect_pc, m_pc);
   endtask

   task automatic step(input string tag, input bit v, input logic [11:0] a, input logic [2:0] op,
                       input logic [4:0] imm, input logic [31:0] rs, input bit we,
                       input bit tr, input logic [31:0] tpc, input bit rt);
      @(negedge clk);
      acc_valid = v; acc_addr = a; acc_op = op; acc_imm = imm; acc_rs1 = rs; acc_wen = we;
      trap_req = tr; trap_pc = tpc; ret_req = rt;
      #1 compare(tag);
   endtask

   task automatic rd(input string tag, input logic [11:0] a);
      step(tag, 1, a, 3'b010, 5'd0, 32'd0, 1'b0, 0, 32'd0, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R6: counter held at zero during reset
      acc_valid = 1; acc_addr = 12'hB00; acc_op = 3'b010;
      repeat (3) @(negedge clk);
      chk("R6", "lo in reset", acc_rdata, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      rd("R6", 12'hB00);
      rd("R6", 12'hB00);
      rd("R6", 12'hB80);
      // R1/R2: write-swap returns old value, stores register source
      step("R2", 1, 12'h305, 3'b001, 5'd0, 32'h8000_0103, 1, 0, 0, 0);
      rd("R1", 12'h305);
      chk("R1", "tvec readback", acc_rdata, 32'h8000_0103);
      step("R2", 1, 12'h341, 3'b101, 5'd19, 32'hFFFF_FFFF, 1, 0, 0, 0);
      rd("R2", 12'h341);
      chk("R2", "imm zero-extend", acc_rdata, 32'd19);
      // R3: set/clear, register and immediate
      step("R3", 1, 12'h305, 3'b010, 5'd0, 32'h0000_0F00, 1, 0, 0, 0);
      step("R3", 1, 12'h305, 3'b111, 5'd1, 32'd0, 1, 0, 0, 0);
      rd("R3", 12'h305);
      chk("R3", "set/clear result", acc_rdata, 32'h8000_0F02);
      step("R3", 1, 12'h305, 3'b110, 5'd4, 32'd0, 1, 0, 0, 0);
      step("R3", 1, 12'h305, 3'b011, 5'd0, 32'h0000_0F00, 1, 0, 0, 0);
      rd("R3", 12'h305);
      // R4: zero-source set/clear and wen low write nothing
      step("R4", 1, 12'h305, 3'b110, 5'd0, 32'd0, 1, 0, 0, 0);
      step("R4", 1, 12'h305, 3'b011, 5'd0, 32'd0, 1, 0, 0, 0);
      step("R4", 1, 12'h305, 3'b001, 5'd0, 32'h1234_5678, 0, 0, 0, 0);
      rd("R4", 12'h305);
      chk("R4", "tvec unchanged", acc_rdata, 32'h8000_0006);
      // R5: illegal address and reserved opcodes
      step("R5", 1, 12'h300, 3'b001, 5'd0, 32'hDEAD_BEEF, 1, 0, 0, 0);
      chk("R5", "illegal flag", {31'd0, acc_illegal}, 32'd1);
      step("R5", 1, 12'h305, 3'b000, 5'd0, 32'hDEAD_BEEF, 1, 0, 0, 0);
      step("R5", 1, 12'h341, 3'b100, 5'd7, 32'hDEAD_BEEF, 1, 0, 0, 0);
      rd("R5", 12'h305);
      chk("R5", "tvec kept", acc_rdata, 32'h8000_0006);
      // R7/R8: low-half wrap carries, writes win
      step("R8", 1, 12'hB00, 3'b001, 5'd0, 32'hFFFF_FFFD, 1, 0, 0, 0);
      rd("R8", 12'hB00);
      chk("R8", "lo written", acc_rdata, 32'hFFFF_FFFD);
      rd("R7", 12'hB80);
      rd("R7", 12'hB80);
      rd("R7", 12'hB80);
      chk("R7", "hi after wrap", acc_rdata, 32'd1);
      step("R8", 1, 12'hB00, 3'b001, 5'd0, 32'hFFFF_FFFF, 1, 0, 0, 0);
      step("R8", 1, 12'hB00, 3'b001, 5'd0, 32'h0000_0010, 1, 0, 0, 0);
      rd("R8", 12'hB80);
      chk("R8", "no carry on lo write", acc_rdata, 32'd1);
      step("R8", 1, 12'hB80, 3'b001, 5'd0, 32'hABCD_0000, 1, 0, 0, 0);
      rd("R8", 12'hB80);
      chk("R8", "hi written", acc_rdata, 32'hABCD_0000);
      rd("R8", 12'hB00);
      // R9: trap redirect and capture
      step("R9", 0, 12'h0, 3'b000, 5'd0, 32'd0, 0, 1, 32'h0000_2000, 0);
      chk("R9", "trap target", redirect_pc, 32'h8000_0004);
      rd("R9", 12'h341);
      chk("R9", "epc capture", acc_rdata, 32'h0000_2000);
      // R10: software adds 4, return goes there
      step("R10", 1, 12'h341, 3'b001, 5'd0, 32'h0000_2004, 1, 0, 0, 0);
      step("R10", 0, 12'h0, 3'b000, 5'd0, 32'd0, 0, 0, 0, 1);
      chk("R10", "return target +4", redirect_pc, 32'h0000_2004);
      // compressed trap, +2
      step("R9", 0, 12'h0, 3'b000, 5'd0, 32'd0, 0, 1, 32'h0000_3006, 0);
      step("R10", 1, 12'h341, 3'b001, 5'd0, 32'h0000_3008, 1, 0, 0, 0);
      step("R10", 0, 12'h0, 3'b000, 5'd0, 32'd0, 0, 0, 0, 1);
      chk("R10", "return target +2", redirect_pc, 32'h0000_3008);
      // R11: trap discards CSR write; trap wins over return
      step("R11", 1, 12'h305, 3'b001, 5'd0, 32'h4444_4444, 1, 1, 32'h0000_5000, 1);
      chk("R11", "trap over return", redirect_pc, 32'h8000_0004);
      rd("R11", 12'h305);
      chk("R11", "tvec not written", acc_rdata, 32'h8000_0006);
      step("R11", 1, 12'h341, 3'b001, 5'd0, 32'h7777_0000, 1, 1, 32'h0000_6000, 0);
      rd("R11", 12'h341);
      chk("R11", "epc from trap", acc_rdata, 32'h0000_6000);
      for (int i = 0; i < 8; i++) rd("R6", 12'hB00);
      @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule